// File: doc/BRIEF.md
# ADC channel sweep sequencer

This block sequences a multi-channel analog-to-digital converter core. A register interface supplies a 16-bit channel-enable mask, a sweep enable, a repeat count, a tag enable, a one-cycle manual trigger and a one-cycle FIFO clear. On a trigger the block walks the enabled channels. For each conversion it presents a channel number with a one-cycle start strobe, and it waits for the core's done pulse with a 12-bit result. Every result is written into a 16-entry result FIFO. When tagging is enabled, the channel number goes into the upper four bits of the word.

Software starts a sequence, waits for the busy flag to drop, then reads the entry count and drains the FIFO. The drain side is a valid/ready stream. A word moves when `rd_valid` and `rd_ready` are both high at a rising clock edge. `rd_data` is meaningful only while `rd_valid` is high and reads as zero when the FIFO is empty. The write side into the FIFO cannot be stalled, because a converter result cannot wait. A result that finds no room is dropped and raises a sticky overflow flag.

Channels 0 to 7 are external inputs and channels 8 to 15 are internal sources. The block treats all sixteen alike.

Top module: `adc_sweep_seq`

## Requirements
- R1: After reset, `busy`, `conv_start`, `overflow` and `rd_valid` are 0, `fifo_count` is 0 and `rd_data` is 0.
- R2: With sweep enabled and a repeat count of 0, one trigger converts every channel whose mask bit is set (bit i enables channel i), exactly once each, in ascending channel order. Each result is pushed in that order.
- R3: With tagging enabled, each FIFO word is {channel[3:0], result[11:0]}. With tagging disabled, bits 15:12 are zero and bits 11:0 hold the result.
- R4: A repeat count N with sweep enabled runs N+1 complete ascending passes over the enabled channels.
- R5: With sweep disabled, a trigger converts only the lowest-numbered enabled channel, N+1 times.
- R6: `busy` is high from the cycle after an accepted trigger until the rising edge at which the last result is pushed. It is low from the cycle that follows that edge.
- R7: A trigger with an all-zero mask is ignored: `busy` stays low and no conversion starts.
- R8: A trigger while `busy` is high is ignored. The mask, mode, count and tag setting in use are those captured at the accepted trigger, so later changes to the configuration inputs do not affect the running sequence.
- R9: A `fifo_clr` pulse empties the FIFO, zeroes `fifo_count` and clears `overflow`. It takes priority over a push or pop in the same cycle.
- R10: The FIFO holds 16 words. A push into a full FIFO with no pop in the same cycle drops the word and sets `overflow`. `overflow` stays set until `fifo_clr` or reset.
- R11: Asserting `rd_ready` while the FIFO is empty leaves `fifo_count` at 0, and `rd_data` reads 0.
- R12: A push and a pop at the same edge leave `fifo_count` unchanged, even when the FIFO is full. The popped word is the oldest, and the new word enters at the tail.
- R13: A `conv_done` pulse that arrives while no conversion is outstanding pushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_chan_en | input | 16 | Channel-enable mask, bit i for channel i |
| cfg_sweep_en | input | 1 | 1: walk all enabled channels; 0: lowest enabled channel only |
| cfg_conv_cnt | input | 4 | Repeat count N, giving N+1 passes |
| cfg_tag_en | input | 1 | Place the channel number in bits 15:12 of each FIFO word |
| trig | input | 1 | One-cycle manual trigger pulse |
| fifo_clr | input | 1 | One-cycle FIFO clear pulse |
| conv_start | output | 1 | One-cycle start-of-conversion strobe to the core |
| conv_chan | output | 4 | Channel the core must convert |
| conv_done | input | 1 | One-cycle done pulse from the core |
| conv_data | input | 12 | Conversion result, valid with `conv_done` |
| busy | output | 1 | A sequence is in progress |
| fifo_count | output | 5 | Number of words held in the FIFO |
| overflow | output | 1 | Sticky flag for a dropped result |
| rd_valid | output | 1 | FIFO holds at least one word |
| rd_ready | input | 1 | Consumer accepts the head word |
| rd_data | output | 16 | Head word of the FIFO, zero when empty |

## Verification
The FIFO write from a finished conversion and the consumer's pop can land on the same rising edge. The bench provokes this with its converter model, which raises `rd_ready` in the very cycle it drives `conv_done`. It does this once while the FIFO holds all 16 words. The result is judged by the entry count, which must stay at 16, by the overflow flag, which must stay low, and by the new head word, which must carry the second-oldest channel. A following push without a pop must then set the overflow flag.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/adc_seq_chan_pick.sv
module adc_seq_chan_pick #(
  parameter int CH_N = 16,
  localparam int CH_W = $clog2(CH_N)
) (
  input  logic [CH_N-1:0] mask_i,
  input  logic [CH_W:0]   from_i,
  output logic            found_o,
  output logic [CH_W-1:0] idx_o
);

  // Lowest set bit at or above from_i; scanning downward leaves the lowest.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = CH_N - 1; i >= 0; i--) begin
      if (mask_i[i] && (int'(from_i) <= i)) begin
        found_o = 1'b1;
        idx_o   = CH_W'(i);
      end
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_N  = 16,
  parameter int RES_W = 12,
  parameter int CNT_W = 4,
  localparam int CH_W   = $clog2(CH_N),
  localparam int WORD_W = CH_W + RES_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_N-1:0]   cfg_chan_en,
  input  logic              cfg_sweep_en,
  input  logic [CNT_W-1:0]  cfg_conv_cnt,
  input  logic              cfg_tag_en,
  input  logic              trig,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              busy,
  output logic              push_valid,
  output logic [WORD_W-1:0] push_word
);

  seq_state_e         state_q;
  logic [CH_N-1:0]    mask_q;
  logic               sweep_q;
  logic               tag_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   pass_q;
  logic [CH_W-1:0]    cur_q;
  logic [CH_W-1:0]    first_q;

  logic               first_found;
  logic [CH_W-1:0]    first_idx;
  logic               next_found;
  logic [CH_W-1:0]    next_idx;
  logic               accept;
  logic               last_pass;

  adc_seq_chan_pick #(.CH_N(CH_N)) u_pick_first (
    .mask_i  (cfg_chan_en),
    .from_i  ('0),
    .found_o (first_found),
    .idx_o   (first_idx)
  );

  adc_seq_chan_pick #(.CH_N(CH_N)) u_pick_next (
    .mask_i  (mask_q),
    .from_i  ({1'b0, cur_q} + (CH_W+1)'(1)),
    .found_o (next_found),
    .idx_o   (next_idx)
  );

  assign accept    = trig && (state_q == SEQ_IDLE) && first_found;
  assign last_pass = (pass_q == cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      mask_q  <= '0;
      sweep_q <= 1'b0;
      tag_q   <= 1'b0;
      cnt_q   <= '0;
      pass_q  <= '0;
      cur_q   <= '0;
      first_q <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            state_q <= SEQ_ISSUE;
            mask_q  <= cfg_chan_en;
            sweep_q <= cfg_sweep_en;
            tag_q   <= cfg_tag_en;
            cnt_q   <= cfg_conv_cnt;
            pass_q  <= '0;
            cur_q   <= first_idx;
            first_q <= first_idx;
          end
        end
        SEQ_ISSUE: state_q <= SEQ_WAIT;
        SEQ_WAIT: begin
          if (conv_done) begin
            if (sweep_q && next_found) begin
              cur_q   <= next_idx;
              state_q <= SEQ_ISSUE;
            end else if (last_pass) begin
              state_q <= SEQ_IDLE;
            end else begin
              pass_q  <= pass_q + CNT_W'(1);
              cur_q   <= first_q;
              state_q <= SEQ_ISSUE;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign conv_start = (state_q == SEQ_ISSUE);
  assign conv_chan  = cur_q;
  assign busy       = (state_q != SEQ_IDLE);
  assign push_valid = (state_q == SEQ_WAIT) && conv_done;
  assign push_word  = tag_q ? {cur_q, conv_data} : {{CH_W{1'b0}}, conv_data};

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R2
  AST_ZERO_MASK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig && (cfg_chan_en == '0)) |=> !busy); // R7
  AST_BUSY_TRIG_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig && !conv_done) |=> $stable(conv_chan)); // R8
  AST_PUSH_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> busy); // R6
  AST_START_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy); // R13

endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_word,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          overflow
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          empty, full, pop_fire, push_ok;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign pop_fire = rd_ready && !empty;
  assign push_ok  = push && (!full || pop_fire);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_ok)  wp_q <= bump(wp_q);
      if (pop_fire) rp_q <= bump(rp_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_fire);
      if (push && !push_ok) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wp_q] <= push_word;
  end

  assign rd_valid = !empty;
  assign rd_data  = empty ? '0 : mem[rp_q];
  assign count    = cnt_q;
  assign overflow = ovf_q;

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow); // R10
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0) && !overflow); // R9
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0)); // R11
  AST_SIMUL_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && rd_ready && rd_valid && !clr) |=> $stable(count)); // R12

endmodule

// File: rtl/adc_sweep_seq.sv
module adc_sweep_seq #(
  parameter int CH_N       = 16,
  parameter int RES_W      = 12,
  parameter int CNT_W      = 4,
  parameter int FIFO_DEPTH = 16,
  localparam int CH_W      = $clog2(CH_N),
  localparam int WORD_W    = CH_W + RES_W,
  localparam int FCNT_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_N-1:0]   cfg_chan_en,
  input  logic              cfg_sweep_en,
  input  logic [CNT_W-1:0]  cfg_conv_cnt,
  input  logic              cfg_tag_en,
  input  logic              trig,
  input  logic              fifo_clr,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              busy,
  output logic [FCNT_W-1:0] fifo_count,
  output logic              overflow,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data
);

  logic              push_valid;
  logic [WORD_W-1:0] push_word;

  adc_seq_ctrl #(
    .CH_N  (CH_N),
    .RES_W (RES_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_chan_en  (cfg_chan_en),
    .cfg_sweep_en (cfg_sweep_en),
    .cfg_conv_cnt (cfg_conv_cnt),
    .cfg_tag_en   (cfg_tag_en),
    .trig         (trig),
    .conv_start   (conv_start),
    .conv_chan    (conv_chan),
    .conv_done    (conv_done),
    .conv_data    (conv_data),
    .busy         (busy),
    .push_valid   (push_valid),
    .push_word    (push_word)
  );

  adc_seq_fifo #(
    .DEPTH (FIFO_DEPTH),
    .W     (WORD_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_clr),
    .push      (push_valid),
    .push_word (push_word),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .count     (fifo_count),
    .overflow  (overflow)
  );

endmodule

// File: tb/adc_sweep_seq_bench.sv
module adc_sweep_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_chan_en = '0;
  logic        cfg_sweep_en = 1'b0;
  logic [3:0]  cfg_conv_cnt = '0;
  logic        cfg_tag_en = 1'b0;
  logic        trig = 1'b0;
  logic        fifo_clr = 1'b0;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        model_done = 1'b0;
  logic        force_done = 1'b0;
  logic        conv_done;
  logic [11:0] conv_data = '0;
  logic        busy;
  logic [4:0]  fifo_count;
  logic        overflow;
  logic        rd_valid;
  logic        tb_ready = 1'b0;
  logic        model_ready = 1'b0;
  logic        rd_ready;
  logic [15:0] rd_data;

  assign conv_done = model_done | force_done;
  assign rd_ready  = tb_ready | model_ready;

  always #2 clk = ~clk;

  adc_sweep_seq u_adc_sweep_seq (
    .clk, .rst_n, .cfg_chan_en, .cfg_sweep_en, .cfg_conv_cnt, .cfg_tag_en,
    .trig, .fifo_clr, .conv_start, .conv_chan, .conv_done, .conv_data,
    .busy, .fifo_count, .overflow, .rd_valid, .rd_ready, .rd_data
  );

  int n_chk = 0;
  int n_fail = 0;

  // Converter model: answers each start after lat cycles, result {chan, index}.
  int   nconv = 0;
  int   lat = 2;
  int   cd = 0;
  bit   pend = 0;
  bit   pop_on_done = 0;
  logic [3:0] pend_ch;
  always @(negedge clk) begin
    model_done  <= 1'b0;
    model_ready <= 1'b0;
    if (pend) begin
      if (cd == 0) begin
        model_done <= 1'b1;
        conv_data  <= {pend_ch, 8'(nconv - 1)};
        pend       <= 0;
        if (pop_on_done) model_ready <= 1'b1;
      end else cd <= cd - 1;
    end else if (conv_start && rst_n) begin
      pend    <= 1;
      cd      <= lat;
      pend_ch <= conv_chan;
      nconv   <= nconv + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  int exp_ch [64];
  int exp_n;

  task automatic build_exp(input logic [15:0] m, input bit sw, input int n);
    int first = 0;
    exp_n = 0;
    for (int c = 15; c >= 0; c--) if (m[c]) first = c;
    for (int p = 0; p <= n; p++) begin
      if (sw) begin
        for (int c = 0; c < 16; c++) if (m[c]) begin exp_ch[exp_n] = c; exp_n++; end
      end else begin
        exp_ch[exp_n] = first; exp_n++;
      end
    end
  endtask

  int base;
  task automatic run_seq(input logic [15:0] m, input bit sw, input logic [3:0] n, input bit tg);
    @(negedge clk);
    cfg_chan_en = m; cfg_sweep_en = sw; cfg_conv_cnt = n; cfg_tag_en = tg;
    base = nconv;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk(busy == 1'b1, "R6 busy after trigger", busy, 1);
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic pop_word(output logic [15:0] w);
    w = rd_data;
    tb_ready = 1'b1;
    @(negedge clk);
    tb_ready = 1'b0;
  endtask

  // {mask, sweep, count, tag}
  localparam logic [21:0] VEC [6] = '{
    {16'h00FF, 1'b1, 4'd0, 1'b1},   // R2 R3 external channels
    {16'h8401, 1'b1, 4'd0, 1'b1},   // R2 sparse mask
    {16'h0004, 1'b0, 4'd0, 1'b0},   // R5 single, R3 tag off
    {16'h0005, 1'b1, 4'd2, 1'b1},   // R4 three passes
    {16'h00A0, 1'b0, 4'd3, 1'b1},   // R5 lowest of two, four times
    {16'hFFFF, 1'b1, 4'd0, 1'b0}    // R2 all sixteen, exactly full
  };

  initial begin
    logic [15:0] w;
    int cnt0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && conv_start == 0, "R1 busy/start in reset", {busy, conv_start}, 0);
    chk(fifo_count == 0 && overflow == 0 && rd_valid == 0 && rd_data == 0,
        "R1 fifo in reset", fifo_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && fifo_count == 0, "R1 after reset", busy, 0);

    for (int v = 0; v < 6; v++) begin
      logic [15:0] m; bit sw; logic [3:0] n; bit tg;
      {m, sw, n, tg} = VEC[v];
      lat = v % 3;
      build_exp(m, sw, int'(n));
      run_seq(m, sw, n, tg);
      chk(busy == 0, "R6 busy low at end", busy, 0);
      chk(fifo_count == 5'(exp_n), "R2/R4/R5 entry count", fifo_count, exp_n);
      chk(overflow == 0, "R10 no overflow when fitting", overflow, 0);
      for (int k = 0; k < exp_n; k++) begin
        logic [15:0] e;
        logic [11:0] d;
        d = {4'(exp_ch[k]), 8'(base + k)};
        e = tg ? {4'(exp_ch[k]), d} : {4'h0, d};
        pop_word(w);
        chk(w == e, tg ? "R2 R3 tagged word order" : "R3 untagged word", w, e);
      end
      chk(rd_valid == 0 && fifo_count == 0, "R11 drained", fifo_count, 0);
    end

    // R7 zero mask
    cnt0 = nconv;
    @(negedge clk);
    cfg_chan_en = 16'h0000; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    chk(busy == 0, "R7 zero mask busy", busy, 0);
    repeat (4) @(negedge clk);
    chk(nconv == cnt0 && fifo_count == 0, "R7 zero mask no conversion", nconv - cnt0, 0);

    // R13 stray done while idle
    force_done = 1'b1; @(negedge clk); force_done = 1'b0;
    @(negedge clk);
    chk(fifo_count == 0 && busy == 0, "R13 stray done ignored", fifo_count, 0);

    // R8 trigger while busy, with new configuration
    lat = 5;
    @(negedge clk);
    cfg_chan_en = 16'h0003; cfg_sweep_en = 1; cfg_conv_cnt = 0; cfg_tag_en = 1;
    trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    repeat (3) @(negedge clk);
    cfg_chan_en = 16'h0010; cfg_conv_cnt = 4'd3; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    chk(fifo_count == 2, "R8 busy trigger ignored count", fifo_count, 2);
    chk(rd_data[15:12] == 4'd0, "R8 first channel", rd_data[15:12], 0);
    pop_word(w);
    chk(rd_data[15:12] == 4'd1, "R8 second channel", rd_data[15:12], 1);
    pop_word(w);
    chk(fifo_count == 0, "R8 no extra words", fifo_count, 0);

    // R12 push and pop in the same edge with FIFO full
    lat = 1;
    run_seq(16'hFFFF, 1'b1, 4'd0, 1'b1);
    chk(fifo_count == 16, "R10 full", fifo_count, 16);
    pop_on_done = 1;
    run_seq(16'h0200, 1'b0, 4'd0, 1'b1);
    pop_on_done = 0;
    @(negedge clk);
    chk(fifo_count == 16, "R12 count unchanged", fifo_count, 16);
    chk(overflow == 0, "R12 no overflow", overflow, 0);
    chk(rd_data[15:12] == 4'd1, "R12 head is second oldest", rd_data[15:12], 1);

    // R10 push into full FIFO without pop
    run_seq(16'h0008, 1'b0, 4'd0, 1'b1);
    @(negedge clk);
    chk(overflow == 1, "R10 overflow set", overflow, 1);
    chk(fifo_count == 16, "R10 count holds", fifo_count, 16);
    repeat (3) @(negedge clk);
    chk(overflow == 1, "R10 overflow sticky", overflow, 1);
    for (int k = 0; k < 15; k++) pop_word(w);
    chk(rd_data[15:12] == 4'd9, "R12 new word at tail", rd_data[15:12], 9);

    // R9 clear
    fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
    chk(fifo_count == 0 && overflow == 0 && rd_valid == 0, "R9 clear",
        {fifo_count, overflow}, 0);

    // R11 pop while empty
    pop_word(w);
    chk(w == 0 && rd_data == 0, "R11 empty read zero", w, 0);
    chk(fifo_count == 0, "R11 empty pop count", fifo_count, 0);

    summary();
    $finish;
  end

endmodule